// File: doc/BRIEF.md
# RV32I Subset Instruction Decoder

This block turns one 32-bit instruction word into the control bundle for a single-cycle integer datapath. It supports a fixed mix of sixteen RV32I instructions:

- register arithmetic and compares: add, sra, slt
- immediate arithmetic: addi, andi, sltiu, srli
- loads and stores: lw, lh, sw, sh
- upper immediates: lui, auipc
- control transfer: jal, jalr, beq

For each word it extracts the three register indices and builds the sign-extended immediate for the word's format. It also picks an ALU operation, operand sources, a write-back source, the memory write strobe and access size, and raises branch and jump flags.

Any other encoding is reported as illegal, and all of its side effects are suppressed. The register file, ALU, memory and program counter sit outside the block. The decoder is purely combinational.

Top module: `rv_subset_decoder`

## Requirements
- R1: The index outputs always copy fixed word fields, for every word: source one is bits 19:15, source two is bits 24:20, destination is bits 11:7.
- R2: The illegal flag is 0 exactly for the sixteen encodings below and 1 for every other word. Each entry gives the major code (bits 6:0), sub-code (bits 14:12) and, where it applies, the upper code (bits 31:25).
  - 0110011 with add 000/0000000, slt 010/0000000, sra 101/0100000.
  - 0010011 with addi 000, sltiu 011, andi 111, and srli 101 with upper code 0000000.
  - 0000011 with lh 001, lw 010.
  - 0100011 with sh 001, sw 010.
  - 1100111 with 000 (jalr), and 1100011 with 000 (beq).
  - 0110111 (lui), 0010111 (auipc) and 1101111 (jal), whatever their other bits.
- R3: For an illegal word, the following outputs are all 0: register write, memory write, branch, jump, immediate, every select and the access size.
- R4: add, slt and sra select ALU codes 0, 2 and 6. Both operands come from registers (A select 0, B select 0), and write-back takes the ALU result (select 0).
- R5: addi, sltiu, andi and srli select ALU codes 0, 3, 4 and 5. Operand B is the immediate (B select 1), built from bits 31:20 and sign-extended. Write-back takes the ALU result.
- R6: lw and lh select ALU code 0 with operand A from a register and operand B the I-format immediate. Write-back takes memory data (select 1). The access size is 2 for lw and 1 for lh. Memory write stays 0.
- R7: sw and sh raise memory write with access size 2 and 1 respectively. The immediate is {31:25, 11:7}, sign-extended. Operand B is the immediate and the ALU code is 0. Register write stays 0.
- R8: lui and auipc produce the immediate bits 31:12 followed by twelve zero bits, with ALU code 0 and B select 1. Operand A is the constant zero (A select 2) for lui and the PC (A select 1) for auipc.
- R9: jal raises jump and selects PC+4 write-back (select 2). Operand A is the PC and operand B the immediate {31, 19:12, 20, 30:21, 0}, sign-extended, with ALU code 0.
- R10: jalr raises jump and selects PC+4 write-back. Operand A is a register and operand B the I-format immediate, with ALU code 0.
- R11: beq raises branch and selects ALU code 1 (subtract) on two register operands. The immediate is {31, 7, 30:25, 11:8, 0}, sign-extended. Register write stays 0.
- R12: Register write is 1 for legal add, slt, sra, addi, sltiu, andi, srli, lw, lh, lui, auipc, jal and jalr words, but only when the destination index is nonzero. It is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr_i | input | 32 | Instruction word |
| rs1_idx_o | output | 5 | First source register index |
| rs2_idx_o | output | 5 | Second source register index |
| rd_idx_o | output | 5 | Destination register index |
| imm_o | output | XLEN | Sign-extended immediate |
| alu_op_o | output | 3 | ALU operation code |
| opa_sel_o | output | 2 | Operand A source: 0 register, 1 PC, 2 zero |
| opb_sel_o | output | 1 | Operand B source: 0 register, 1 immediate |
| wb_sel_o | output | 2 | Write-back source: 0 ALU, 1 memory, 2 PC+4 |
| reg_we_o | output | 1 | Register file write enable |
| mem_we_o | output | 1 | Memory write enable |
| mem_size_o | output | 2 | Access size: 0 none, 1 halfword, 2 word |
| branch_o | output | 1 | Conditional branch |
| jump_o | output | 1 | Unconditional jump |
| illegal_o | output | 1 | Word is outside the supported set |

## Verification
Every result is due in the same cycle as the word that causes it, because no register lies between input and output. The bench changes the word just after a rising edge and samples all outputs at the following falling edge, half a period later. Each sample is compared with a model of the encoding table written out in the bench. Random words are drawn both from the sixteen templates and as unconstrained words. Directed words cover near-miss encodings, a zero destination and extreme immediates.

// File: rtl/rvd_pkg.sv
package rvd_pkg;

   localparam logic [6:0] OPC_OP     = 7'b0110011;
   localparam logic [6:0] OPC_OPIMM  = 7'b0010011;
   localparam logic [6:0] OPC_LOAD   = 7'b0000011;
   localparam logic [6:0] OPC_STORE  = 7'b0100011;
   localparam logic [6:0] OPC_LUI    = 7'b0110111;
   localparam logic [6:0] OPC_AUIPC  = 7'b0010111;
   localparam logic [6:0] OPC_JAL    = 7'b1101111;
   localparam logic [6:0] OPC_JALR   = 7'b1100111;
   localparam logic [6:0] OPC_BRANCH = 7'b1100011;

   localparam int REG_IDX_W = 5;

   typedef enum logic [2:0] {
      IMM_NONE = 3'd0,
      IMM_I    = 3'd1,
      IMM_S    = 3'd2,
      IMM_B    = 3'd3,
      IMM_U    = 3'd4,
      IMM_J    = 3'd5
   } imm_fmt_e;

   typedef enum logic [2:0] {
      ALU_ADD  = 3'd0,
      ALU_SUB  = 3'd1,
      ALU_SLT  = 3'd2,
      ALU_SLTU = 3'd3,
      ALU_AND  = 3'd4,
      ALU_SRL  = 3'd5,
      ALU_SRA  = 3'd6
   } alu_op_e;

   typedef enum logic [1:0] {
      OPA_REG  = 2'd0,
      OPA_PC   = 2'd1,
      OPA_ZERO = 2'd2
   } opa_e;

   typedef enum logic {
      OPB_REG = 1'b0,
      OPB_IMM = 1'b1
   } opb_e;

   typedef enum logic [1:0] {
      WB_ALU = 2'd0,
      WB_MEM = 2'd1,
      WB_PC4 = 2'd2
   } wb_e;

   typedef enum logic [1:0] {
      MSZ_NONE = 2'd0,
      MSZ_HALF = 2'd1,
      MSZ_WORD = 2'd2
   } msize_e;

   typedef struct packed {
      logic     legal;
      logic     reg_wr;
      logic     mem_we;
      logic     branch;
      logic     jump;
      alu_op_e  alu_op;
      opa_e     opa;
      opb_e     opb;
      wb_e      wb;
      msize_e   msize;
      imm_fmt_e imm_fmt;
   } ctrl_t;

endpackage

// File: rtl/rvd_fields.sv
module rvd_fields
   import rvd_pkg::*;
#(
   parameter int ILEN = 32
) (
   input  logic [ILEN-1:0]      word_i,
   output logic [6:0]           opc_o,
   output logic [2:0]           f3_o,
   output logic [6:0]           f7_o,
   output logic [REG_IDX_W-1:0] rs1_o,
   output logic [REG_IDX_W-1:0] rs2_o,
   output logic [REG_IDX_W-1:0] rd_o
);

   generate
      if (ILEN != 32) begin : g_bad_ilen
         $error("rvd_fields: ILEN must be 32");
      end
   endgenerate

   assign opc_o = word_i[6:0];
   assign rd_o  = word_i[11:7];
   assign f3_o  = word_i[14:12];
   assign rs1_o = word_i[19:15];
   assign rs2_o = word_i[24:20];
   assign f7_o  = word_i[31:25];

endmodule

// File: rtl/rvd_imm_gen.sv
module rvd_imm_gen
   import rvd_pkg::*;
#(
   parameter int XLEN = 32
) (
   input  logic [31:0]     word_i,
   input  imm_fmt_e        fmt_i,
   output logic [XLEN-1:0] imm_o
);

   localparam int EXT_I = XLEN - 11;
   localparam int EXT_B = XLEN - 12;
   localparam int EXT_U = XLEN - 31;
   localparam int EXT_J = XLEN - 20;

   generate
      if (XLEN < 32) begin : g_bad_xlen
         $error("rvd_imm_gen: XLEN must be at least 32");
      end
   endgenerate

   logic s;
   assign s = word_i[31];

   always_comb begin
      case (fmt_i)
         IMM_I:   imm_o = {{EXT_I{s}}, word_i[30:20]};
         IMM_S:   imm_o = {{EXT_I{s}}, word_i[30:25], word_i[11:7]};
         IMM_B:   imm_o = {{EXT_B{s}}, word_i[7], word_i[30:25], word_i[11:8], 1'b0};
         IMM_U:   imm_o = {{EXT_U{s}}, word_i[30:12], 12'b0};
         IMM_J:   imm_o = {{EXT_J{s}}, word_i[19:12], word_i[20], word_i[30:21], 1'b0};
         default: imm_o = '0;
      endcase
   end

   always_comb begin
      if (!$isunknown({word_i, fmt_i})) begin
         // R5/R7/R8/R9/R11: every format carries bit 31 as its sign
         p_imm_sign_r5: assert (fmt_i == IMM_NONE || imm_o[XLEN-1] == word_i[31]);
         // R9/R11: control-transfer offsets are even
         p_imm_even_r9: assert (!(fmt_i == IMM_B || fmt_i == IMM_J) || imm_o[0] == 1'b0);
      end
   end

endmodule

// File: rtl/rvd_ctrl.sv
module rvd_ctrl
   import rvd_pkg::*;
(
   input  logic [6:0] opc_i,
   input  logic [2:0] f3_i,
   input  logic [6:0] f7_i,
   output ctrl_t      ctrl_o
);

   logic f7_zero, f7_alt;
   assign f7_zero = (f7_i == 7'b0000000);
   assign f7_alt  = (f7_i == 7'b0100000);

   always_comb begin
      ctrl_t c;
      c = '0;
      case (opc_i)
         OPC_OP: begin
            c.reg_wr = 1'b1;
            c.opa    = OPA_REG;
            c.opb    = OPB_REG;
            c.wb     = WB_ALU;
            c.imm_fmt = IMM_NONE;
            if (f7_zero && f3_i == 3'b000) begin
               c.legal = 1'b1; c.alu_op = ALU_ADD;
            end else if (f7_zero && f3_i == 3'b010) begin
               c.legal = 1'b1; c.alu_op = ALU_SLT;
            end else if (f7_alt && f3_i == 3'b101) begin
               c.legal = 1'b1; c.alu_op = ALU_SRA;
            end
         end
         OPC_OPIMM: begin
            c.reg_wr  = 1'b1;
            c.opa     = OPA_REG;
            c.opb     = OPB_IMM;
            c.wb      = WB_ALU;
            c.imm_fmt = IMM_I;
            case (f3_i)
               3'b000: begin c.legal = 1'b1; c.alu_op = ALU_ADD;  end
               3'b011: begin c.legal = 1'b1; c.alu_op = ALU_SLTU; end
               3'b111: begin c.legal = 1'b1; c.alu_op = ALU_AND;  end
               3'b101: begin c.legal = f7_zero; c.alu_op = ALU_SRL; end
               default: c.legal = 1'b0;
            endcase
         end
         OPC_LOAD: begin
            c.reg_wr  = 1'b1;
            c.opa     = OPA_REG;
            c.opb     = OPB_IMM;
            c.wb      = WB_MEM;
            c.alu_op  = ALU_ADD;
            c.imm_fmt = IMM_I;
            if (f3_i == 3'b010) begin
               c.legal = 1'b1; c.msize = MSZ_WORD;
            end else if (f3_i == 3'b001) begin
               c.legal = 1'b1; c.msize = MSZ_HALF;
            end
         end
         OPC_STORE: begin
            c.mem_we  = 1'b1;
            c.opa     = OPA_REG;
            c.opb     = OPB_IMM;
            c.alu_op  = ALU_ADD;
            c.imm_fmt = IMM_S;
            if (f3_i == 3'b010) begin
               c.legal = 1'b1; c.msize = MSZ_WORD;
            end else if (f3_i == 3'b001) begin
               c.legal = 1'b1; c.msize = MSZ_HALF;
            end
         end
         OPC_LUI, OPC_AUIPC: begin
            c.legal   = 1'b1;
            c.reg_wr  = 1'b1;
            c.opa     = (opc_i == OPC_LUI) ? OPA_ZERO : OPA_PC;
            c.opb     = OPB_IMM;
            c.alu_op  = ALU_ADD;
            c.wb      = WB_ALU;
            c.imm_fmt = IMM_U;
         end
         OPC_JAL: begin
            c.legal   = 1'b1;
            c.reg_wr  = 1'b1;
            c.jump    = 1'b1;
            c.opa     = OPA_PC;
            c.opb     = OPB_IMM;
            c.alu_op  = ALU_ADD;
            c.wb      = WB_PC4;
            c.imm_fmt = IMM_J;
         end
         OPC_JALR: begin
            c.legal   = (f3_i == 3'b000);
            c.reg_wr  = 1'b1;
            c.jump    = 1'b1;
            c.opa     = OPA_REG;
            c.opb     = OPB_IMM;
            c.alu_op  = ALU_ADD;
            c.wb      = WB_PC4;
            c.imm_fmt = IMM_I;
         end
         OPC_BRANCH: begin
            c.legal   = (f3_i == 3'b000);
            c.branch  = 1'b1;
            c.opa     = OPA_REG;
            c.opb     = OPB_REG;
            c.alu_op  = ALU_SUB;
            c.imm_fmt = IMM_B;
         end
         default: c.legal = 1'b0;
      endcase
      if (!c.legal) begin
         c = '0;
      end
      ctrl_o = c;
   end

   always_comb begin
      if (!$isunknown({opc_i, f3_i, f7_i})) begin
         // R7/R11: stores and branches never request a register write
         p_no_wr_on_store_r7: assert (!(ctrl_o.mem_we || ctrl_o.branch) || !ctrl_o.reg_wr);
         // R2: at most one of store, branch, jump per word
         p_one_kind_r2: assert ($onehot0({ctrl_o.mem_we, ctrl_o.branch, ctrl_o.jump}));
      end
   end

endmodule

// File: rtl/rv_subset_decoder.sv
module rv_subset_decoder
   import rvd_pkg::*;
#(
   parameter int XLEN          = 32,
   parameter bit ZERO_REG_HARD = 1'b1
) (
   input  logic [31:0]     instr_i,
   output logic [4:0]      rs1_idx_o,
   output logic [4:0]      rs2_idx_o,
   output logic [4:0]      rd_idx_o,
   output logic [XLEN-1:0] imm_o,
   output logic [2:0]      alu_op_o,
   output logic [1:0]      opa_sel_o,
   output logic            opb_sel_o,
   output logic [1:0]      wb_sel_o,
   output logic            reg_we_o,
   output logic            mem_we_o,
   output logic [1:0]      mem_size_o,
   output logic            branch_o,
   output logic            jump_o,
   output logic            illegal_o
);

   generate
      if (XLEN < 32) begin : g_bad_xlen
         $error("rv_subset_decoder: XLEN must be at least 32");
      end
   endgenerate

   logic [6:0] opc;
   logic [2:0] f3;
   logic [6:0] f7;
   ctrl_t      ctrl;
   logic       rd_nonzero;

   rvd_fields #(.ILEN(32)) u_fields (
      .word_i (instr_i),
      .opc_o  (opc),
      .f3_o   (f3),
      .f7_o   (f7),
      .rs1_o  (rs1_idx_o),
      .rs2_o  (rs2_idx_o),
      .rd_o   (rd_idx_o)
   );

   rvd_ctrl u_ctrl (
      .opc_i  (opc),
      .f3_i   (f3),
      .f7_i   (f7),
      .ctrl_o (ctrl)
   );

   rvd_imm_gen #(.XLEN(XLEN)) u_imm (
      .word_i (instr_i),
      .fmt_i  (ctrl.imm_fmt),
      .imm_o  (imm_o)
   );

   assign rd_nonzero = |rd_idx_o;

   generate
      if (ZERO_REG_HARD) begin : g_x0_guard
         assign reg_we_o = ctrl.reg_wr & rd_nonzero;
      end else begin : g_x0_free
         assign reg_we_o = ctrl.reg_wr;
      end
   endgenerate

   assign alu_op_o   = ctrl.alu_op;
   assign opa_sel_o  = ctrl.opa;
   assign opb_sel_o  = ctrl.opb;
   assign wb_sel_o   = ctrl.wb;
   assign mem_we_o   = ctrl.mem_we;
   assign mem_size_o = ctrl.msize;
   assign branch_o   = ctrl.branch;
   assign jump_o     = ctrl.jump;
   assign illegal_o  = ~ctrl.legal;

   always_comb begin
      if (!$isunknown(instr_i)) begin
         // R3: an illegal word has no side effects
         p_illegal_quiet_r3: assert (!illegal_o ||
            (!reg_we_o && !mem_we_o && !branch_o && !jump_o));
         // R12: destination zero is never written
         p_x0_no_write_r12: assert (!ZERO_REG_HARD || rd_nonzero || !reg_we_o);
         // R9/R10: jumps link through PC+4
         p_jump_links_r9: assert (!jump_o || wb_sel_o == WB_PC4);
         // R6: a memory access carries a size, a store a nonzero size
         p_store_sized_r6: assert (!mem_we_o || mem_size_o != MSZ_NONE);
      end
   end

endmodule

// File: tb/rv_subset_decoder_test.sv
module rv_subset_decoder_test;

   localparam int CLK_PERIOD = 10;
   localparam int N_RANDOM   = 3000;
   localparam int WD_LIMIT   = 100000;

   logic clk = 1'b0;
   logic rst = 1'b1;
   always #(CLK_PERIOD/2) clk = ~clk;

   logic [31:0] instr;
   logic [4:0]  rs1, rs2, rd;
   logic [31:0] imm;
   logic [2:0]  alu_op;
   logic [1:0]  opa, wb, msz;
   logic        opb, reg_we, mem_we, br, jmp, ill;

   rv_subset_decoder uut (
      .instr_i    (instr),
      .rs1_idx_o  (rs1),
      .rs2_idx_o  (rs2),
      .rd_idx_o   (rd),
      .imm_o      (imm),
      .alu_op_o   (alu_op),
      .opa_sel_o  (opa),
      .opb_sel_o  (opb),
      .wb_sel_o   (wb),
      .reg_we_o   (reg_we),
      .mem_we_o   (mem_we),
      .mem_size_o (msz),
      .branch_o   (br),
      .jump_o     (jmp),
      .illegal_o  (ill)
   );

   typedef struct packed {
      logic        ill;
      logic        we, mwe, br, jmp;
      logic [2:0]  alu;
      logic [1:0]  opa;
      logic        opb;
      logic [1:0]  wb, msz;
      logic [31:0] imm;
   } exp_t;

   int n_cmp = 0;
   int n_bad = 0;
   int cycles = 0;
   bit done = 0;

   function automatic logic [31:0] sx(logic [31:0] v, int top);
      logic [31:0] r;
      for (int i = 0; i < 32; i++) r[i] = (i <= top) ? v[i] : v[top];
      return r;
   endfunction

   function automatic exp_t model(logic [31:0] w);
      exp_t e;
      logic [6:0] op;
      logic [2:0] f3;
      logic [6:0] f7;
      logic [31:0] ii, si, bi, ui, ji;
      logic ok, wr;
      op = w[6:0]; f3 = w[14:12]; f7 = w[31:25];
      ii = sx({20'b0, w[31:20]}, 11);
      si = sx({20'b0, w[31:25], w[11:7]}, 11);
      bi = sx({19'b0, w[31], w[7], w[30:25], w[11:8], 1'b0}, 12);
      ui = {w[31:12], 12'b0};
      ji = sx({11'b0, w[31], w[19:12], w[20], w[30:21], 1'b0}, 20);
      e = '0; ok = 0; wr = 0;
      case (op)
         7'b0110011: begin
            wr = 1;
            if (f7 == 7'h00 && f3 == 3'd0) begin ok = 1; e.alu = 3'd0; end
            if (f7 == 7'h00 && f3 == 3'd2) begin ok = 1; e.alu = 3'd2; end
            if (f7 == 7'h20 && f3 == 3'd5) begin ok = 1; e.alu = 3'd6; end
         end
         7'b0010011: begin
            wr = 1; e.opb = 1; e.imm = ii;
            if (f3 == 3'd0) begin ok = 1; e.alu = 3'd0; end
            if (f3 == 3'd3) begin ok = 1; e.alu = 3'd3; end
            if (f3 == 3'd7) begin ok = 1; e.alu = 3'd4; end
            if (f3 == 3'd5 && f7 == 7'h00) begin ok = 1; e.alu = 3'd5; end
         end
         7'b0000011: begin
            wr = 1; e.opb = 1; e.imm = ii; e.wb = 2'd1;
            if (f3 == 3'd2) begin ok = 1; e.msz = 2'd2; end
            if (f3 == 3'd1) begin ok = 1; e.msz = 2'd1; end
         end
         7'b0100011: begin
            e.mwe = 1; e.opb = 1; e.imm = si;
            if (f3 == 3'd2) begin ok = 1; e.msz = 2'd2; end
            if (f3 == 3'd1) begin ok = 1; e.msz = 2'd1; end
         end
         7'b0110111: begin ok = 1; wr = 1; e.opa = 2'd2; e.opb = 1; e.imm = ui; end
         7'b0010111: begin ok = 1; wr = 1; e.opa = 2'd1; e.opb = 1; e.imm = ui; end
         7'b1101111: begin
            ok = 1; wr = 1; e.jmp = 1; e.opa = 2'd1; e.opb = 1; e.wb = 2'd2; e.imm = ji;
         end
         7'b1100111: begin
            ok = (f3 == 3'd0); wr = 1; e.jmp = 1; e.opb = 1; e.wb = 2'd2; e.imm = ii;
         end
         7'b1100011: begin
            ok = (f3 == 3'd0); e.br = 1; e.alu = 3'd1; e.imm = bi;
         end
         default: ok = 0;
      endcase
      e.we = wr && (w[11:7] != 5'd0);
      if (!ok) e = '0;
      e.ill = !ok;
      return e;
   endfunction

   function automatic string tag(logic [31:0] w);
      case (w[6:0])
         7'b0110011: return "R4";
         7'b0010011: return "R5";
         7'b0000011: return "R6";
         7'b0100011: return "R7";
         7'b0110111, 7'b0010111: return "R8";
         7'b1101111: return "R9";
         7'b1100111: return "R10";
         7'b1100011: return "R11";
         default: return "R2";
      endcase
   endfunction

   task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s instr=%08h actual=%08h expected=%08h", req, what, instr, act, exp);
      end
   endtask

   task automatic apply(logic [31:0] w);
      exp_t e;
      string t, te;
      @(posedge clk);
      #1 instr = w;
      @(negedge clk);
      e = model(w);
      t = tag(w);
      // R1: field extraction, every word
      chk("R1", "rs1", {27'b0, rs1}, {27'b0, w[19:15]});
      chk("R1", "rs2", {27'b0, rs2}, {27'b0, w[24:20]});
      chk("R1", "rd",  {27'b0, rd},  {27'b0, w[11:7]});
      chk("R2", "illegal", {31'b0, ill}, {31'b0, e.ill});
      te = e.ill ? "R3" : t;
      chk(e.ill ? "R3" : ((w[11:7] == 5'd0) ? "R12" : t), "reg_we", {31'b0, reg_we}, {31'b0, e.we});
      chk(te, "mem_we", {31'b0, mem_we}, {31'b0, e.mwe});
      chk(te, "branch", {31'b0, br},     {31'b0, e.br});
      chk(te, "jump",   {31'b0, jmp},    {31'b0, e.jmp});
      chk(te, "alu_op", {29'b0, alu_op}, {29'b0, e.alu});
      chk(te, "opa",    {30'b0, opa},    {30'b0, e.opa});
      chk(te, "opb",    {31'b0, opb},    {31'b0, e.opb});
      chk(te, "wb",     {30'b0, wb},     {30'b0, e.wb});
      chk(te, "size",   {30'b0, msz},    {30'b0, e.msz});
      chk(te, "imm",    imm,             e.imm);
   endtask

   function automatic logic [31:0] templ(int k, logic [31:0] r);
      logic [31:0] w;
      w = r;
      case (k)
         0:  begin w[6:0] = 7'b0110011; w[14:12] = 3'd0; w[31:25] = 7'h00; end
         1:  begin w[6:0] = 7'b0110011; w[14:12] = 3'd5; w[31:25] = 7'h20; end
         2:  begin w[6:0] = 7'b0110011; w[14:12] = 3'd2; w[31:25] = 7'h00; end
         3:  begin w[6:0] = 7'b0010011; w[14:12] = 3'd5; w[31:25] = 7'h00; end
         4:  begin w[6:0] = 7'b0010011; w[14:12] = 3'd3; end
         5:  begin w[6:0] = 7'b0010011; w[14:12] = 3'd7; end
         6:  begin w[6:0] = 7'b0010011; w[14:12] = 3'd0; end
         7:  begin w[6:0] = 7'b0000011; w[14:12] = 3'd2; end
         8:  begin w[6:0] = 7'b0000011; w[14:12] = 3'd1; end
         9:  begin w[6:0] = 7'b1100111; w[14:12] = 3'd0; end
         10: w[6:0] = 7'b0010111;
         11: w[6:0] = 7'b0110111;
         12: begin w[6:0] = 7'b0100011; w[14:12] = 3'd2; end
         13: begin w[6:0] = 7'b0100011; w[14:12] = 3'd1; end
         14: w[6:0] = 7'b1101111;
         15: begin w[6:0] = 7'b1100011; w[14:12] = 3'd0; end
         default: w = r;
      endcase
      return w;
   endfunction

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles > WD_LIMIT && !done) begin
         done = 1;
         n_bad++;
         $display("FAIL watchdog expired");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      instr = 32'h0;
      repeat (3) @(posedge clk);
      rst = 1'b0;
      // R2/R3: all-zero word is illegal and quiet
      apply(32'h0000_0000);
      apply(32'hFFFF_FFFF);
      // R12: add with destination zero
      apply(32'h0020_8033);
      // R2: subtract form, shift-left immediate, arithmetic shift immediate rejected
      apply(32'h4020_80B3);
      apply(32'h0030_9093);
      apply(32'h4030_D093);
      // R2: byte load and byte store rejected, bne rejected, jalr sub-code 001 rejected
      apply(32'h0000_8083);
      apply(32'h0010_8023);
      apply(32'h0020_9063);
      apply(32'h0000_90E7);
      // R11: beq with most negative offset
      apply(32'h8000_0063);
      // R9: jal with most negative offset
      apply(32'h8000_00EF);
      // R8: lui with all-ones upper field
      apply(32'hFFFF_F0B7);
      // R10: jalr negative offset, R7: sh negative offset
      apply(32'h8000_80E7);
      apply(32'hFE20_9FA3);
      for (int i = 0; i < N_RANDOM; i++) begin
         int k;
         k = int'($urandom % 18);
         apply(templ(k, $urandom));
      end
      if (!done) begin
         done = 1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

endmodule